// File: doc/BRIEF.md
# Pack/Unpack Element Offset Sequencer

This block produces the element offsets for a vector register move that can gather subvectors from separate planes or scatter them into separate planes. A start pulse captures five settings: a vector length, a source subvector length, a destination subvector length, and two layout selects. The block then presents one (source offset, destination offset) pair per transfer on a valid/ready handshake. When the last pair has been taken it raises a one-cycle done pulse. The block does not move any data and does not access the register file.

Each side has its own offset generator. Each generator holds an element counter `i` (0 to VL-1) and a lane counter `j` (0 to its subvector length S-1). On every accepted transfer the lane counter steps, and when it wraps the element counter steps, so the two sides advance in lock-step. A side in interleaved layout emits `j + S*i`. A side in planar layout emits `i + VL*j`. With the gather select set, the source reads planes and the destination writes interleaved data, which packs the data. The scatter select does the reverse for the destination, which unpacks it. Both selects may be set together.

Top module: `pku_seq`

## Requirements
- R1: A start pulse while the block is idle captures the configuration and zeroes both generators. In the next cycle `pair_valid_o` is 1 and the pair is (0, 0).
- R2: A side in interleaved layout emits offset k for its k-th pair (k counted from 0). This equals `j + S*i` with `i = k / S` and `j = k % S`.
- R3: When `gather_en_i` is 1, the source side uses planar layout: for its k-th pair it emits `i + VL*j`, with `i = k / S_src` and `j = k % S_src`.
- R4: When `scatter_en_i` is 1, the destination side uses planar layout: for its k-th pair it emits `i + VL*j`, with `i = k / S_dst` and `j = k % S_dst`.
- R5: Setting both selects is legal. Both sides then use planar layout, each with its own subvector length.
- R6: A run delivers exactly VL*min(S_src, S_dst) pairs and ends as soon as either side has emitted its final offset.
- R7: `done_o` is 1 for exactly one cycle, in the cycle after the last pair is accepted. In that cycle `pair_valid_o` is 0.
- R8: While `pair_valid_o` is 1 and `pair_ready_i` is 0, both offsets and `pair_valid_o` hold their values in the next cycle.
- R9: A start pulse while a run is in progress is ignored. The run continues with the configuration it already captured.
- R10: Captured settings are clamped. A vector length of 0 becomes 1, and one above 64 becomes 64. A subvector length of 0 becomes 1, and one above 4 becomes 4.
- R11: After reset, `pair_valid_o` and `done_o` are 0 and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures configuration when idle |
| vl_i | input | 7 | Vector length (1..64) |
| src_sv_i | input | 3 | Source subvector length (1..4) |
| dst_sv_i | input | 3 | Destination subvector length (1..4) |
| gather_en_i | input | 1 | Source uses planar layout |
| scatter_en_i | input | 1 | Destination uses planar layout |
| pair_valid_o | output | 1 | An offset pair is presented |
| pair_ready_i | input | 1 | Consumer accepts the pair |
| src_off_o | output | 8 | Source element offset |
| dst_off_o | output | 8 | Destination element offset |
| done_o | output | 1 | One-cycle pulse after the last pair |

## Verification
A generator whose lane or element counter has gone wrong sends an incorrect offset to the port on the next accepted pair. Because the bench compares every pair against its arithmetic formula, the fault is caught within one transfer. A wrong end condition shows up on the first run whose two subvector lengths differ, as `done_o` arriving too early or too late. A stall or start-while-busy fault is visible within one cycle as a changed offset. The sweep covers every pair of subvector lengths under all four layout combinations, at several vector lengths including both ends of the range.

// File: rtl/pku_pkg.sv
package pku_pkg;
    localparam int MAX_VL = 64;
    localparam int MAX_SV = 4;
    localparam int VL_W   = $clog2(MAX_VL) + 1;
    localparam int SV_W   = $clog2(MAX_SV) + 1;
    localparam int LANE_W = $clog2(MAX_SV);
    localparam int OFF_W  = $clog2(MAX_VL * MAX_SV);
    localparam int SIDES  = 2;

    typedef struct packed {
        logic [VL_W-1:0]   elem;
        logic [LANE_W-1:0] lane;
    } gen_state_t;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [VL_W-1:0]   vl;
        logic [SV_W-1:0]   src_sv;
        logic [SV_W-1:0]   dst_sv;
        logic              gather;
        logic              scatter;
    } ctl_state_t;
endpackage

// File: rtl/pku_idx_gen.sv
module pku_idx_gen
    import pku_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [SV_W-1:0]  sv_i,
    input  logic             planar_i,
    output logic [OFF_W-1:0] off_o,
    output logic             last_o
);
    localparam int WIDE_W = 16;

    gen_state_t st_d, st_q;
    logic       lane_end;
    logic       elem_end;
    logic [WIDE_W-1:0] off_wide;

    always_comb begin
        lane_end = ({{(SV_W-LANE_W){1'b0}}, st_q.lane} == sv_i - SV_W'(1));
        elem_end = (st_q.elem == vl_i - VL_W'(1));
        last_o   = lane_end && elem_end;
        if (planar_i) begin
            off_wide = WIDE_W'(st_q.elem) + WIDE_W'(vl_i) * WIDE_W'(st_q.lane);
        end else begin
            off_wide = WIDE_W'(st_q.lane) + WIDE_W'(sv_i) * WIDE_W'(st_q.elem);
        end
        off_o = off_wide[OFF_W-1:0];

        st_d = st_q;
        if (load_i) begin
            st_d.elem = '0;
            st_d.lane = '0;
        end else if (step_i) begin
            if (lane_end) begin
                st_d.lane = '0;
                st_d.elem = st_q.elem + VL_W'(1);
            end else begin
                st_d.lane = st_q.lane + LANE_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the controller never steps a generator past its final offset
    assert_no_step_past_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(step_i && last_o));

    // R2 / R3: an emitted offset stays inside the VL*S element window
    assert_offset_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (WIDE_W'(off_o) < WIDE_W'(vl_i) * WIDE_W'(sv_i)));
endmodule

// File: rtl/pku_seq.sv
module pku_seq
    import pku_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [VL_W-1:0]  vl_i,
    input  logic [SV_W-1:0]  src_sv_i,
    input  logic [SV_W-1:0]  dst_sv_i,
    input  logic             gather_en_i,
    input  logic             scatter_en_i,
    output logic             pair_valid_o,
    input  logic             pair_ready_i,
    output logic [OFF_W-1:0] src_off_o,
    output logic [OFF_W-1:0] dst_off_o,
    output logic             done_o
);
    ctl_state_t ctl_d, ctl_q;

    logic accept;
    logic finish;
    logic load;
    logic step;

    logic [SIDES-1:0][SV_W-1:0]  side_sv;
    logic [SIDES-1:0]            side_planar;
    logic [SIDES-1:0][OFF_W-1:0] side_off;
    logic [SIDES-1:0]            side_last;

    function automatic logic [VL_W-1:0] clamp_vl(input logic [VL_W-1:0] v);
        if (v == '0)               return VL_W'(1);
        if (v > VL_W'(MAX_VL))     return VL_W'(MAX_VL);
        return v;
    endfunction

    function automatic logic [SV_W-1:0] clamp_sv(input logic [SV_W-1:0] s);
        if (s == '0)               return SV_W'(1);
        if (s > SV_W'(MAX_SV))     return SV_W'(MAX_SV);
        return s;
    endfunction

    always_comb begin
        accept = ctl_q.busy && pair_ready_i;
        finish = accept && (|side_last);
        load   = start_i && !ctl_q.busy;
        step   = accept && !finish;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (load) begin
            ctl_d.busy    = 1'b1;
            ctl_d.vl      = clamp_vl(vl_i);
            ctl_d.src_sv  = clamp_sv(src_sv_i);
            ctl_d.dst_sv  = clamp_sv(dst_sv_i);
            ctl_d.gather  = gather_en_i;
            ctl_d.scatter = scatter_en_i;
        end else if (finish) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q         <= '0;
            ctl_q.vl      <= VL_W'(1);
            ctl_q.src_sv  <= SV_W'(1);
            ctl_q.dst_sv  <= SV_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign side_sv[0]     = ctl_q.src_sv;
    assign side_sv[1]     = ctl_q.dst_sv;
    assign side_planar[0] = ctl_q.gather;
    assign side_planar[1] = ctl_q.scatter;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        pku_idx_gen u_gen (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .load_i   (load),
            .step_i   (step),
            .vl_i     (ctl_q.vl),
            .sv_i     (side_sv[g]),
            .planar_i (side_planar[g]),
            .off_o    (side_off[g]),
            .last_o   (side_last[g])
        );
    end

    assign pair_valid_o = ctl_q.busy;
    assign done_o       = ctl_q.done;
    assign src_off_o    = side_off[0];
    assign dst_off_o    = side_off[1];

    // R8: a stalled pair is held unchanged
    assert_hold_when_stalled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pair_valid_o && !pair_ready_i) |=>
            (pair_valid_o && $stable(src_off_o) && $stable(dst_off_o)));

    // R7: done only follows an accepted transfer and never overlaps valid
    assert_done_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!pair_valid_o && $past(pair_valid_o && pair_ready_i)));

    // R9: a start during a run leaves the captured configuration untouched
    assert_busy_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.busy && start_i) |=>
            ($stable(ctl_q.vl) && $stable(ctl_q.src_sv) && $stable(ctl_q.dst_sv)
             && $stable(ctl_q.gather) && $stable(ctl_q.scatter)));

    // R10: captured lengths always lie in their legal ranges
    assert_cfg_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.vl >= VL_W'(1)) && (ctl_q.vl <= VL_W'(MAX_VL))
        && (ctl_q.src_sv >= SV_W'(1)) && (ctl_q.src_sv <= SV_W'(MAX_SV))
        && (ctl_q.dst_sv >= SV_W'(1)) && (ctl_q.dst_sv <= SV_W'(MAX_SV)));
endmodule

// File: tb/pku_seq_tb.sv
module pku_seq_tb;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start_i = 1'b0;
    logic [6:0] vl_i = '0;
    logic [2:0] src_sv_i = '0;
    logic [2:0] dst_sv_i = '0;
    logic       gather_en_i = 1'b0;
    logic       scatter_en_i = 1'b0;
    logic       pair_ready_i = 1'b0;
    logic       pair_valid_o;
    logic [7:0] src_off_o;
    logic [7:0] dst_off_o;
    logic       done_o;

    int n_checks = 0;
    int n_errors = 0;
    int stall_cnt = 0;

    always #10 clk_i = ~clk_i;

    pku_seq u_dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .vl_i         (vl_i),
        .src_sv_i     (src_sv_i),
        .dst_sv_i     (dst_sv_i),
        .gather_en_i  (gather_en_i),
        .scatter_en_i (scatter_en_i),
        .pair_valid_o (pair_valid_o),
        .pair_ready_i (pair_ready_i),
        .src_off_o    (src_off_o),
        .dst_off_o    (dst_off_o),
        .done_o       (done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_off(input int k, input int s, input int vl, input bit planar);
        int i = k / s;
        int j = k % s;
        return planar ? (i + vl * j) : k;
    endfunction

    task automatic run(input int rvl, input int rs, input int rd, input bit pk, input bit up,
                       input int evl, input int es, input int ed);
        int n = evl * ((es < ed) ? es : ed);
        string stag = pk ? (up ? "R5 src" : "R3 src") : "R2 src";
        string dtag = up ? (pk ? "R5 dst" : "R4 dst") : "R2 dst";
        @(negedge clk_i);
        start_i = 1'b1; vl_i = 7'(rvl); src_sv_i = 3'(rs); dst_sv_i = 3'(rd);
        gather_en_i = pk; scatter_en_i = up; pair_ready_i = 1'b0;
        @(negedge clk_i);
        start_i = 1'b0;
        check("R1 valid after start", pair_valid_o, 1);
        check("R1 first src", src_off_o, 0);
        check("R1 first dst", dst_off_o, 0);
        for (int k = 0; k < n; k++) begin
            if (stall_cnt % 5 == 2) begin
                pair_ready_i = 1'b0;
                start_i = 1'b1; vl_i = 7'd7; src_sv_i = 3'd1; dst_sv_i = 3'd2;
                gather_en_i = ~pk; scatter_en_i = ~up;
                @(negedge clk_i);
                start_i = 1'b0;
                check("R8 valid held", pair_valid_o, 1);
                check("R8/R9 src held", src_off_o, exp_off(k, es, evl, pk));
                check("R8/R9 dst held", dst_off_o, exp_off(k, ed, evl, up));
            end
            stall_cnt++;
            pair_ready_i = 1'b1;
            check(stag, src_off_o, exp_off(k, es, evl, pk));
            check(dtag, dst_off_o, exp_off(k, ed, evl, up));
            if (pair_valid_o !== 1'b1) check("R6 valid until last", pair_valid_o, 1);
            if (done_o !== 1'b0) check("R7 no early done", done_o, 0);
            @(negedge clk_i);
        end
        pair_ready_i = 1'b0;
        check("R6/R7 done after last pair", done_o, 1);
        check("R7 valid low with done", pair_valid_o, 0);
        @(negedge clk_i);
        check("R7 done one cycle", done_o, 0);
    endtask

    initial begin
        #50_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int vls[4] = '{1, 3, 5, 64};
        repeat (3) @(negedge clk_i);
        check("R11 valid at reset", pair_valid_o, 0);
        check("R11 done at reset", done_o, 0);
        rst_ni = 1'b1;
        repeat (2) @(negedge clk_i);
        check("R11 valid idle", pair_valid_o, 0);
        check("R11 done idle", done_o, 0);
        check("R11 src offset", src_off_o, 0);
        check("R11 dst offset", dst_off_o, 0);
        foreach (vls[v]) begin
            for (int s = 1; s <= 4; s++) begin
                for (int d = 1; d <= 4; d++) begin
                    for (int m = 0; m < 4; m++) begin
                        run(vls[v], s, d, m[0], m[1], vls[v], s, d);
                    end
                end
            end
        end
        // R10: clamping of out-of-range settings
        run(0, 0, 7, 1'b1, 1'b0, 1, 1, 4);
        run(100, 7, 0, 1'b0, 1'b1, 64, 4, 1);
        run(127, 5, 6, 1'b1, 1'b1, 64, 4, 4);
        run(2, 0, 3, 1'b0, 1'b1, 2, 1, 3);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule